// File: doc/BRIEF.md
# Oscillator Enable Register with Mode-Aware Protection

This block holds the four enable bits that switch on the oscillators of a small microcontroller clock controller: the slow crystal, the fast crystal, the slow RC and the fast RC oscillator. Software writes the bits through a simple write strobe. The hardware keeps an enable on while its oscillator is requested, ignores writes that would switch off an oscillator that is requested or in use, and drops the fast-oscillator enables by itself when a clock-mode switch completes.

The clock controller supplies two 3-bit codes. The requested source code gives the clock the controller is moving to. The current mode code gives the clock now running. A one-cycle completion pulse is raised in the cycle in which the current mode code first shows the new mode. The block also keeps the mode that was in force before the last completed switch, which some automatic clears depend on. Each enable bit takes its new value on the next rising clock edge. The four enables are presented as a vector.

Top module: `osc_enable_ctrl`

## Requirements
- R1: Clock codes are 3'b000 slow crystal (enable bit 3), 3'b010 fast crystal (bit 2), 3'b100 slow RC (bit 1), 3'b110 fast RC and 3'b111 fast RC with multiplier (both bit 0). Codes 3'b001, 3'b011 and 3'b101 select no oscillator. Reset gives 4'b0001 (the bit of the default source 3'b110), and the remembered previous mode resets to 3'b110.
- R2: A write loads bit i from the write data on the next edge when no other rule applies: 1 enables, 0 disables.
- R3: While the requested code selects an oscillator, that oscillator's bit is 1 after the next edge, whatever is written.
- R4: A write of 0 to a bit is ignored while the requested code or the current mode code selects that bit's oscillator.
- R5: While the current mode code is 3'b000 or 3'b100, a write of 1 to bit 2 or bit 0 is ignored.
- R6: On a completion pulse whose current mode code is not 3'b010, bit 2 is cleared.
- R7: On a completion pulse, bit 0 is cleared if the current mode code is not 3'b110, or if the previous mode was 3'b111. The previous mode is the current mode code captured at the last completion pulse.
- R8: Bits 3 and 1 are never cleared by a completion pulse.
- R9: Priority in one cycle: forced set (R3) wins over automatic clear (R6, R7), and automatic clear wins over a software write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 4 | Enable values to write |
| src_req | input | 3 | Requested clock source code |
| mode_cur | input | 3 | Current clock mode code |
| mode_done | input | 1 | One-cycle pulse marking a completed mode switch |
| osc_en | output | 4 | Oscillator enables, bit 3 slow crystal down to bit 0 fast RC |

## Verification
The assertions assume that the mode codes are stable and known in every cycle after reset. They also assume that the completion pulse is judged against the current mode code presented in the same cycle, because that value becomes the remembered previous mode. The stimulus changes every input only on the falling clock edge and never leaves an input unknown. It walks every pairing of requested and current code with every write pattern, and it raises the completion pulse in a scattered pattern, including cycles where a write or a forced set arrives together with the pulse.

// File: rtl/osc_en_pkg.sv
package osc_en_pkg;
  localparam int CODE_W = 3;
  localparam int N_OSC  = 4;

  // Enable bit positions
  localparam int B_SUBX  = 3;
  localparam int B_MAINX = 2;
  localparam int B_SUBRC = 1;
  localparam int B_MAINRC = 0;

  // Clock codes
  localparam logic [CODE_W-1:0] C_SUBX   = 3'b000;
  localparam logic [CODE_W-1:0] C_MAINX  = 3'b010;
  localparam logic [CODE_W-1:0] C_SUBRC  = 3'b100;
  localparam logic [CODE_W-1:0] C_MAINRC = 3'b110;
  localparam logic [CODE_W-1:0] C_MRCPLL = 3'b111;

  // One-hot set of enable bits whose oscillator a code uses
  function automatic logic [N_OSC-1:0] code_to_mask(input logic [CODE_W-1:0] c);
    logic [N_OSC-1:0] m;
    m = '0;
    m[B_SUBX]   = (c == C_SUBX);
    m[B_MAINX]  = (c == C_MAINX);
    m[B_SUBRC]  = (c == C_SUBRC);
    m[B_MAINRC] = (c == C_MAINRC) || (c == C_MRCPLL);
    return m;
  endfunction

  // Modes running from a slow oscillator
  function automatic logic is_slow_mode(input logic [CODE_W-1:0] c);
    return (c == C_SUBX) || (c == C_SUBRC);
  endfunction

  // Bits that can refuse a write of 1 in slow modes
  function automatic logic [N_OSC-1:0] fast_mask();
    logic [N_OSC-1:0] m;
    m = '0;
    m[B_MAINX]  = 1'b1;
    m[B_MAINRC] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/osc_mode_tracker.sv
module osc_mode_tracker
  import osc_en_pkg::*;
#(
  parameter logic [CODE_W-1:0] RESET_MODE = C_MAINRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_done,
  input  logic [CODE_W-1:0] mode_cur,
  output logic [CODE_W-1:0] mode_prev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_prev <= RESET_MODE;
    else if (mode_done) mode_prev <= mode_cur;
  end

  // R7: the remembered mode follows the code seen with the pulse
  a_r7_prev_capture: assert property (@(posedge clk) disable iff (!rst_n)
    mode_done |=> (mode_prev == $past(mode_cur)));
  a_r7_prev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_done |=> $stable(mode_prev));
endmodule

// File: rtl/osc_rule_decode.sv
module osc_rule_decode
  import osc_en_pkg::*;
(
  input  logic [CODE_W-1:0] src_req,
  input  logic [CODE_W-1:0] mode_cur,
  input  logic [CODE_W-1:0] mode_prev,
  input  logic              mode_done,
  output logic [N_OSC-1:0]  force_on,
  output logic [N_OSC-1:0]  guard_off,
  output logic [N_OSC-1:0]  block_on,
  output logic [N_OSC-1:0]  auto_clr
);
  logic [N_OSC-1:0] req_mask;
  logic [N_OSC-1:0] cur_mask;
  logic             drop_main;
  logic             drop_mrc;

  always_comb begin
    req_mask = code_to_mask(src_req);
    cur_mask = code_to_mask(mode_cur);
  end

  assign force_on  = req_mask;
  assign guard_off = req_mask | cur_mask;
  assign block_on  = is_slow_mode(mode_cur) ? fast_mask() : '0;

  assign drop_main = mode_done && (mode_cur != C_MAINX);
  assign drop_mrc  = mode_done && ((mode_cur != C_MAINRC) || (mode_prev == C_MRCPLL));

  always_comb begin
    auto_clr           = '0;
    auto_clr[B_MAINX]  = drop_main;
    auto_clr[B_MAINRC] = drop_mrc;
  end
endmodule

// File: rtl/osc_bit_cell.sv
module osc_bit_cell #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_on,
  input  logic auto_clr,
  input  logic guard_off,
  input  logic block_on,
  input  logic wr_en,
  input  logic wr_bit,
  output logic q
);
  logic wr_ok;
  logic d;

  assign wr_ok = wr_en && !(guard_off && !wr_bit) && !(block_on && wr_bit);

  always_comb begin
    if (force_on)      d = 1'b1;
    else if (auto_clr) d = 1'b0;
    else if (wr_ok)    d = wr_bit;
    else               d = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_VAL;
    else        q <= d;
  end

  a_r3_forced_set: assert property (@(posedge clk) disable iff (!rst_n)
    force_on |=> q);
  a_r9_clear_over_write: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_clr && !force_on) |=> !q);
  a_r4_guarded_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_off && !auto_clr && q) |=> q);
  a_r5_blocked_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
    (block_on && !force_on && !q) |=> !q);
  a_r2_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !force_on && !auto_clr && !(guard_off && !wr_bit) && !(block_on && wr_bit))
      |=> (q == $past(wr_bit)));
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !force_on && !auto_clr) |=> $stable(q));
endmodule

// File: rtl/osc_enable_ctrl.sv
module osc_enable_ctrl
  import osc_en_pkg::*;
#(
  parameter logic [CODE_W-1:0] RESET_SRC = C_MAINRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [N_OSC-1:0]  wr_data,
  input  logic [CODE_W-1:0] src_req,
  input  logic [CODE_W-1:0] mode_cur,
  input  logic              mode_done,
  output logic [N_OSC-1:0]  osc_en
);
  localparam logic [N_OSC-1:0] RESET_VAL = code_to_mask(RESET_SRC);

  logic [CODE_W-1:0] mode_prev;
  logic [N_OSC-1:0]  force_on;
  logic [N_OSC-1:0]  guard_off;
  logic [N_OSC-1:0]  block_on;
  logic [N_OSC-1:0]  auto_clr;

  osc_mode_tracker #(.RESET_MODE(RESET_SRC)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_done (mode_done),
    .mode_cur  (mode_cur),
    .mode_prev (mode_prev)
  );

  osc_rule_decode u_rules (
    .src_req   (src_req),
    .mode_cur  (mode_cur),
    .mode_prev (mode_prev),
    .mode_done (mode_done),
    .force_on  (force_on),
    .guard_off (guard_off),
    .block_on  (block_on),
    .auto_clr  (auto_clr)
  );

  for (genvar i = 0; i < N_OSC; i++) begin : g_bit
    osc_bit_cell #(.RESET_VAL(RESET_VAL[i])) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .force_on  (force_on[i]),
      .auto_clr  (auto_clr[i]),
      .guard_off (guard_off[i]),
      .block_on  (block_on[i]),
      .wr_en     (wr_en),
      .wr_bit    (wr_data[i]),
      .q         (osc_en[i])
    );
  end

  a_r1_reset_value: assert property (@(posedge clk)
    !rst_n |=> (osc_en == RESET_VAL));
  a_r6_main_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_done && mode_cur != C_MAINX && src_req != C_MAINX) |=> !osc_en[B_MAINX]);
  a_r7_mrc_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_done && (mode_cur != C_MAINRC || mode_prev == C_MRCPLL) && src_req[2:1] != 2'b11)
      |=> !osc_en[B_MAINRC]);
  a_r8_slow_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_done && !wr_en) |=> (osc_en[B_SUBX] == $past(osc_en[B_SUBX]) || $past(src_req) == C_SUBX)
                               && (osc_en[B_SUBRC] == $past(osc_en[B_SUBRC]) || $past(src_req) == C_SUBRC));
endmodule

// File: tb/sim_osc_enable_ctrl.sv
module sim_osc_enable_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic [2:0] src_req = 3'b110;
  logic [2:0] mode_cur = 3'b110;
  logic       mode_done = 1'b0;
  logic [3:0] osc_en;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [3:0] m_q;
  logic [2:0] m_prev;

  always #5 clk = ~clk;

  osc_enable_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .src_req(src_req), .mode_cur(mode_cur), .mode_done(mode_done), .osc_en(osc_en)
  );

  // Does code c run the oscillator of enable bit i (R1)
  function automatic logic uses(input int i, input logic [2:0] c);
    case (i)
      3: return c == 3'd0;
      2: return c == 3'd2;
      1: return c == 3'd4;
      default: return c == 3'd6 || c == 3'd7;
    endcase
  endfunction

  function automatic logic [3:0] ref_next(input logic [3:0] q, input logic [2:0] pv,
      input logic w, input logic [3:0] d, input logic [2:0] rq, input logic [2:0] cu,
      input logic dn);
    logic [3:0] n;
    n = q;
    if (w) begin
      for (int i = 0; i < 4; i++) begin
        if (d[i]) begin
          if (!((i == 2 || i == 0) && (cu == 3'd0 || cu == 3'd4))) n[i] = 1'b1;
        end else if (!(uses(i, rq) || uses(i, cu))) begin
          n[i] = 1'b0;
        end
      end
    end
    if (dn) begin
      if (cu != 3'd2) n[2] = 1'b0;
      if (cu != 3'd6 || pv == 3'd7) n[0] = 1'b0;
    end
    for (int i = 0; i < 4; i++) if (uses(i, rq)) n[i] = 1'b1;
    return n;
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (osc_en !== exp) begin
      errors++;
      $display("FAIL %s osc_en=%b expected=%b", req, osc_en, exp);
    end
  endtask

  task automatic step(input logic w, input logic [3:0] d, input logic [2:0] rq,
      input logic [2:0] cu, input logic dn);
    @(negedge clk);
    wr_en = w; wr_data = d; src_req = rq; mode_cur = cu; mode_done = dn;
    @(posedge clk);
    #1;
  endtask

  // {wr, wdata, req, cur, done, expected}
  localparam int NV = 17;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 4'b0000, 3'o6, 3'o6, 1'b0, 4'b0001},  // R3 fast RC forced
    {1'b1, 4'b1111, 3'o6, 3'o6, 1'b0, 4'b1111},  // R2 all written on
    {1'b1, 4'b0000, 3'o6, 3'o6, 1'b0, 4'b0001},  // R4 bit0 guarded
    {1'b0, 4'b0000, 3'o2, 3'o6, 1'b0, 4'b0101},  // R3 fast crystal forced
    {1'b0, 4'b0000, 3'o2, 3'o2, 1'b1, 4'b0100},  // R7 leave fast RC
    {1'b1, 4'b0000, 3'o2, 3'o2, 1'b0, 4'b0100},  // R4 bit2 guarded
    {1'b0, 4'b0000, 3'o0, 3'o2, 1'b0, 4'b1100},  // R3 slow crystal forced
    {1'b0, 4'b0000, 3'o0, 3'o0, 1'b1, 4'b1000},  // R6 leave fast crystal
    {1'b1, 4'b0111, 3'o0, 3'o0, 1'b0, 4'b1010},  // R5 fast bits refuse 1
    {1'b1, 4'b0000, 3'o4, 3'o0, 1'b0, 4'b1010},  // R4 cur guards bit3
    {1'b0, 4'b0000, 3'o4, 3'o4, 1'b1, 4'b1010},  // R8 slow bits kept
    {1'b1, 4'b0101, 3'o4, 3'o4, 1'b0, 4'b0010},  // R5 and R2
    {1'b0, 4'b0000, 3'o7, 3'o4, 1'b0, 4'b0011},  // R3 multiplier code
    {1'b0, 4'b0000, 3'o7, 3'o7, 1'b1, 4'b0011},  // R9 force beats clear
    {1'b1, 4'b1111, 3'o6, 3'o7, 1'b0, 4'b1111},  // R2 writes in mode 7
    {1'b0, 4'b0000, 3'o1, 3'o6, 1'b1, 4'b1010},  // R7 out of mode 7
    {1'b1, 4'b0101, 3'o1, 3'o6, 1'b1, 4'b0001}   // R9 clear beats write
  };

  initial begin
    m_q = 4'b0001;
    m_prev = 3'd6;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset value", 4'b0001);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 idle after reset", 4'b0001);

    // Table of hand-derived vectors
    for (int k = 0; k < NV; k++) begin
      logic [15:0] v;
      v = VEC[k];
      step(v[15], v[14:11], v[10:8], v[7:5], v[4]);
      check($sformatf("R2-table vector %0d", k), v[3:0]);
      m_q = v[3:0];
      if (v[4]) m_prev = v[7:5];
    end

    // Sweep every requested/current pairing with every write pattern
    for (int rq = 0; rq < 8; rq++) begin
      for (int cu = 0; cu < 8; cu++) begin
        for (int d = 0; d < 16; d++) begin
          logic w, dn;
          logic [3:0] e;
          w  = (d != 7);
          dn = ((rq + cu + d) % 5) == 0;
          e  = ref_next(m_q, m_prev, w, 4'(d), 3'(rq), 3'(cu), dn);
          step(w, 4'(d), 3'(rq), 3'(cu), dn);
          check($sformatf("R3/R4/R5/R6/R7/R8/R9 sweep req=%0d cur=%0d", rq, cu), e);
          m_q = e;
          if (dn) m_prev = 3'(cu);
        end
      end
    end

    // Reset in mid-run, then check the remembered mode went back to 3'b110 (R1, R7)
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 4'b0001);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 4'b0001, 3'o1, 3'o6, 1'b1);
    check("R7 prev mode reset to 6 keeps bit0", 4'b0001);
    step(1'b0, 4'b0000, 3'o1, 3'o6, 1'b0);
    check("R2 hold without write", 4'b0001);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule